// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block gathers one non-maskable request and sixteen maskable request positions, and presents to a CPU the single most urgent request as a registered valid flag plus a 5-bit source code. The maskable positions form four groups of four. A software-held ranking decides which group is most urgent. Inside a group the order is fixed: position 0 first, position 3 last. One position is reserved and never raises a request.

Eight positions are wired to external pins. Each of these pins can be set to edge or level detection. The other positions come from on-chip peripherals and are always treated as edge (pulse) events. Every position has a pending flag and a mask bit. The CPU pulses an acknowledge while a code is presented, and this clears the pending flag of that source. A global enable blocks all maskable requests but never blocks the non-maskable one. Vector fetch, context saving and the exception sequence are left to the CPU.

Position `p` of group `g` is source index `4*g + p` and is presented as code `4*g + p`. The non-maskable request is presented as code 31. External positions are indices 0, 1, 2, 4, 5, 8, 9 and 12. Index 15 is reserved.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A rising edge on `nmi_in` sets a non-maskable pending flag. From the clock edge that samples the rise, the block shows `irq_valid`=1 and `irq_code`=31, whatever the mask, the enable and the other pending requests. An acknowledge while code 31 is shown clears the flag. A held-high `nmi_in` does not set the flag again.
- R2: A maskable winner is shown as code `4*g+p`. Within one group, the lowest position that is pending wins.
- R3: `grp_rank[2g+1:2g]` is the rank of group g, and rank 0 is the most urgent. Among the groups that hold an eligible request, the group with the smallest rank wins. When ranks are equal, the lower group index wins.
- R4: When `irq_mask[i]`=1, source i is kept out of arbitration, but its pending flag is kept. Clearing the mask bit presents the source again without a new edge.
- R5: An edge-mode source becomes pending on a 0-to-1 input transition. An acknowledge while its code is shown clears it, and it is not shown again until a new rising edge.
- R6: An external position whose `level_mode` bit is 1 requests for as long as its input is high. An acknowledge has no effect on it, and the request drops at the clock edge that samples the input low.
- R7: When `glob_en`=0, no maskable code is shown and maskable pending flags are kept. The non-maskable request is still shown.
- R8: Reserved index 15 never produces a request and code 15 is never shown.
- R9: During reset, and right after it, `irq_valid`=0 and `irq_code`=0, and every pending flag is cleared. When nothing is eligible, the outputs are 0 and 0.
- R10: An internal (non-external) position is always edge mode. Its `level_mode` bit is ignored, so it stays pending after its input falls until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-edge detected |
| irq_in | input | 16 | Maskable request inputs by source index |
| irq_mask | input | 16 | 1 = source excluded from arbitration |
| level_mode | input | 16 | 1 = level detection (external positions only) |
| grp_rank | input | 8 | 2-bit rank per group, 0 most urgent |
| glob_en | input | 1 | Global enable for maskable requests |
| irq_ack | input | 1 | Acknowledge of the presented code |
| irq_valid | output | 1 | A request is presented |
| irq_code | output | 5 | Winning source code, 31 for the non-maskable request |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `irq_ack` is only pulsed while a code is presented, and that `grp_rank` holds a permutation. The stimulus drives every input on the falling edge and acknowledges only a code the bench has just observed. It uses only the identity ranking and its reverse, so the group tie-break is never exercised. Mask and enable checks compare the presented code against the mask and enable values that were present at the clock edge that loaded it.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
   // result of a group-level pick
   typedef struct packed {
      logic       vld;
      logic [1:0] grp;
   } grp_pick_t;

   // non-maskable code sits at the top of the code space
   function automatic int nmi_code_of(input int code_w);
      return (1 << code_w) - 1;
   endfunction
endpackage

// File: rtl/grp_irq_src_cell.sv
module grp_irq_src_cell #(
   parameter bit IS_EXT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   input  logic level_mode,
   input  logic clr,
   output logic req_nxt
);
   localparam logic EXT_L = IS_EXT;

   logic prev_q, pend_q, pend_d, lvl, rise;

   assign lvl  = level_mode & EXT_L;   // internal sources are always edge (R10)
   assign rise = req_in & ~prev_q;

   generate
      if (IS_EXT) begin : g_ext
         assign pend_d = lvl ? 1'b0 : ((pend_q & ~clr) | rise);
         assign req_nxt = lvl ? req_in : pend_d;
      end else begin : g_int
         assign pend_d  = (pend_q & ~clr) | rise;
         assign req_nxt = pend_d;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= req_in;
         pend_q <= pend_d;
      end
   end
endmodule

// File: rtl/grp_irq_leader.sv
module grp_irq_leader #(
   parameter int GSZ = 4,
   localparam int GW = (GSZ > 1) ? $clog2(GSZ) : 1
) (
   input  logic [GSZ-1:0] req,
   output logic           any,
   output logic [GW-1:0]  idx
);
   always_comb begin
      idx = '0;
      for (int p = GSZ - 1; p >= 0; p--) begin
         if (req[p]) idx = GW'(p);
      end
   end
   assign any = |req;
endmodule

// File: rtl/grp_irq_rank_pick.sv
module grp_irq_rank_pick
   import grp_irq_pkg::*;
#(
   parameter int NGRP = 4,
   localparam int RW = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic [NGRP-1:0]    any,
   input  logic [NGRP*RW-1:0] rank,
   output logic               win_vld,
   output logic [RW-1:0]      win_grp
);
   logic [RW-1:0] best_r;

   always_comb begin
      win_vld = 1'b0;
      win_grp = '0;
      best_r  = '1;
      for (int g = 0; g < NGRP; g++) begin
         // strict compare keeps the lower index on a tie
         if (any[g] && (!win_vld || (rank[g*RW +: RW] < best_r))) begin
            win_vld = 1'b1;
            win_grp = RW'(g);
            best_r  = rank[g*RW +: RW];
         end
      end
   end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
   import grp_irq_pkg::*;
#(
   parameter int          NGRP     = 4,
   parameter int          GSZ      = 4,
   parameter int          CODE_W   = 5,
   parameter logic [15:0] EXT_POS  = 16'h1337,
   parameter int          RSVD_POS = 15,
   localparam int NSRC = NGRP * GSZ,
   localparam int RW   = $clog2(NGRP),
   localparam int GW   = $clog2(GSZ)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nmi_in,
   input  logic [NSRC-1:0]      irq_in,
   input  logic [NSRC-1:0]      irq_mask,
   input  logic [NSRC-1:0]      level_mode,
   input  logic [NGRP*RW-1:0]   grp_rank,
   input  logic                 glob_en,
   input  logic                 irq_ack,
   output logic                 irq_valid,
   output logic [CODE_W-1:0]    irq_code
);
   localparam logic [CODE_W-1:0] NMI_CODE = CODE_W'(nmi_code_of(CODE_W));
   localparam logic [NSRC-1:0]   RSVD_BIT = NSRC'(1) << RSVD_POS;

   initial begin
      assert (NSRC == 16) else $error("source map sized for 16 positions");
      assert (NGRP > 1 && GSZ > 1) else $error("need at least two groups and positions");
      assert (RW + GW <= CODE_W) else $error("code width too small");
      assert (NSRC < nmi_code_of(CODE_W)) else $error("codes collide with NMI code");
      assert (RSVD_POS < NSRC) else $error("reserved position out of range");
   end

   logic [NSRC-1:0] src_req, elig, clr;
   logic            nmi_clr, nmi_req;
   logic [NGRP-1:0] grp_any;
   logic [GW-1:0]   lead_idx [NGRP];
   logic            win_vld;
   logic [RW-1:0]   win_grp;
   logic            ack_hit;

   assign ack_hit = irq_ack & irq_valid;
   assign nmi_clr = ack_hit & (irq_code == NMI_CODE);

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         assign clr[i] = ack_hit & (irq_code == CODE_W'(i));
         grp_irq_src_cell #(.IS_EXT(EXT_POS[i] && (i != RSVD_POS))) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_in     (irq_in[i]),
            .level_mode (level_mode[i]),
            .clr        (clr[i]),
            .req_nxt    (src_req[i])
         );
      end
   endgenerate

   grp_irq_src_cell #(.IS_EXT(1'b0)) u_nmi (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_in     (nmi_in),
      .level_mode (1'b0),
      .clr        (nmi_clr),
      .req_nxt    (nmi_req)
   );

   assign elig = src_req & ~irq_mask & ~RSVD_BIT & {NSRC{glob_en}};

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         grp_irq_leader #(.GSZ(GSZ)) u_lead (
            .req (elig[g*GSZ +: GSZ]),
            .any (grp_any[g]),
            .idx (lead_idx[g])
         );
      end
   endgenerate

   grp_irq_rank_pick #(.NGRP(NGRP)) u_pick (
      .any     (grp_any),
      .rank    (grp_rank),
      .win_vld (win_vld),
      .win_grp (win_grp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid <= 1'b0;
         irq_code  <= '0;
      end else if (nmi_req) begin
         irq_valid <= 1'b1;
         irq_code  <= NMI_CODE;
      end else if (win_vld) begin
         irq_valid <= 1'b1;
         irq_code  <= CODE_W'({win_grp, lead_idx[win_grp]});
      end else begin
         irq_valid <= 1'b0;
         irq_code  <= '0;
      end
   end
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
   parameter int NSRC     = 16,
   parameter int CODE_W   = 5,
   parameter int RSVD_POS = 15,
   localparam int IW = $clog2(NSRC)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              nmi_in,
   input logic [NSRC-1:0]   irq_mask,
   input logic              glob_en,
   input logic              irq_valid,
   input logic [CODE_W-1:0] irq_code
);
   localparam logic [CODE_W-1:0] NMI_C = '1;

   logic [NSRC-1:0] mask_q;
   logic            glob_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         glob_q <= 1'b0;
      end else begin
         mask_q <= irq_mask;
         glob_q <= glob_en;
      end
   end

   assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_in) |=> (irq_valid && irq_code == NMI_C));

   assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_code == NMI_C || irq_code < CODE_W'(NSRC)));

   assert_mask_hides_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_code != NMI_C) |-> !mask_q[irq_code[IW-1:0]]);

   assert_enable_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_code != NMI_C) |-> glob_q);

   assert_rsvd_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_code != CODE_W'(RSVD_POS)));

   assert_reset_idle_R9: assert property (@(posedge clk)
      !rst_n |-> (!irq_valid && irq_code == '0));
endmodule

bind grp_irq_ctrl grp_irq_chk #(
   .NSRC(NSRC), .CODE_W(CODE_W), .RSVD_POS(RSVD_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nmi_in    (nmi_in),
   .irq_mask  (irq_mask),
   .glob_en   (glob_en),
   .irq_valid (irq_valid),
   .irq_code  (irq_code)
);

// File: tb/grp_irq_ctrl_bench.sv
module grp_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        nmi_in;
   logic [15:0] irq_in, irq_mask, level_mode;
   logic [7:0]  grp_rank;
   logic        glob_en, irq_ack;
   logic        irq_valid;
   logic [4:0]  irq_code;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   grp_irq_ctrl u_grp_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
      .irq_mask(irq_mask), .level_mode(level_mode), .grp_rank(grp_rank),
      .glob_en(glob_en), .irq_ack(irq_ack), .irq_valid(irq_valid),
      .irq_code(irq_code)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic        ack, glob, nmi;
      logic [7:0]  rank;
      logic [15:0] lvl, msk, din;
      logic        ev;
      logic [4:0]  ec;
   } vec_t;

   localparam int NV = 28;
   // rq, ack, glob, nmi, rank, level, mask, inputs, exp valid, exp code
   localparam vec_t VEC [NV] = '{
      {4'd2, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0000, 1'b0,5'd0},
      {4'd2, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0040, 1'b1,5'd6},
      {4'd2, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0060, 1'b1,5'd5},
      {4'd3, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b1,5'd5},
      {4'd3, 1'b0,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h0460, 1'b1,5'd10},
      {4'd5, 1'b1,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h0460, 1'b1,5'd5},
      {4'd5, 1'b1,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h0460, 1'b1,5'd6},
      {4'd4, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0040,16'h0460, 1'b0,5'd0},
      {4'd4, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b1,5'd6},
      {4'd1, 1'b0,1'b0,1'b1, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b1,5'd31},
      {4'd7, 1'b1,1'b0,1'b1, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b0,5'd0},
      {4'd7, 1'b0,1'b1,1'b1, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b1,5'd6},
      {4'd5, 1'b1,1'b1,1'b1, 8'hE4, 16'h0000,16'h0000,16'h0460, 1'b0,5'd0},
      {4'd5, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0000, 1'b0,5'd0},
      {4'd6, 1'b0,1'b1,1'b0, 8'hE4, 16'h0004,16'h0000,16'h0004, 1'b1,5'd2},
      {4'd6, 1'b1,1'b1,1'b0, 8'hE4, 16'h0004,16'h0000,16'h0004, 1'b1,5'd2},
      {4'd6, 1'b0,1'b1,1'b0, 8'hE4, 16'h0004,16'h0000,16'h0000, 1'b0,5'd0},
      {4'd8, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h8000, 1'b0,5'd0},
      {4'd10,1'b0,1'b1,1'b0, 8'hE4, 16'h0008,16'h0000,16'h8008, 1'b1,5'd3},
      {4'd10,1'b0,1'b1,1'b0, 8'hE4, 16'h0008,16'h0000,16'h8000, 1'b1,5'd3},
      {4'd10,1'b1,1'b1,1'b0, 8'hE4, 16'h0008,16'h0000,16'h8000, 1'b0,5'd0},
      {4'd8, 1'b0,1'b1,1'b0, 8'hE4, 16'h0000,16'h0000,16'h0000, 1'b0,5'd0},
      {4'd3, 1'b0,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h1001, 1'b1,5'd12},
      {4'd5, 1'b1,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h1001, 1'b1,5'd0},
      {4'd5, 1'b1,1'b1,1'b0, 8'h1B, 16'h0000,16'h0000,16'h1001, 1'b0,5'd0},
      {4'd1, 1'b0,1'b1,1'b1, 8'h1B, 16'h0000,16'h0000,16'h1003, 1'b1,5'd31},
      {4'd1, 1'b1,1'b1,1'b1, 8'h1B, 16'h0000,16'h0000,16'h1003, 1'b1,5'd1},
      {4'd5, 1'b1,1'b1,1'b1, 8'h1B, 16'h0000,16'h0000,16'h1003, 1'b0,5'd0}
   };

   function automatic string tag_of(input logic [3:0] n);
      case (n)
         4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
         4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
         4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check_out(input string tag, input logic ev, input logic [4:0] ec);
      checks++;
      if (irq_valid !== ev || irq_code !== ec) begin
         failures++;
         $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                  tag, irq_valid, irq_code, ev, ec);
      end
   endtask

   initial begin
      rst_n = 1'b0; nmi_in = 1'b0; irq_in = '0; irq_mask = '0;
      level_mode = '0; grp_rank = 8'hE4; glob_en = 1'b1; irq_ack = 1'b0;
      repeat (3) @(negedge clk);
      check_out("R9", 1'b0, 5'd0);           // R9: idle during reset
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         irq_ack = VEC[k].ack; glob_en = VEC[k].glob; nmi_in = VEC[k].nmi;
         grp_rank = VEC[k].rank; level_mode = VEC[k].lvl;
         irq_mask = VEC[k].msk; irq_in = VEC[k].din;
         @(negedge clk);
         check_out(tag_of(VEC[k].rq), VEC[k].ev, VEC[k].ec);
      end
      // directed R5: edge on internal position 7 (GR1 pos3)
      irq_ack = 1'b0; nmi_in = 1'b0; irq_in = 16'h0080;
      grp_rank = 8'hE4; level_mode = '0; irq_mask = '0;
      @(negedge clk);
      check_out("R5", 1'b1, 5'd7);
      // directed R9: reset mid-run clears pending and outputs
      rst_n = 1'b0; irq_in = '0;
      #2;
      check_out("R9", 1'b0, 5'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R9", 1'b0, 5'd0);
      @(negedge clk);
      check_out("R9", 1'b0, 5'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule